// File: doc/BRIEF.md
# Qualified Sample-Stream Peak Detector

This block finds transition peaks in a stream of signed, already digitized read-back samples. Each accepted peak stands for a stored binary one. The block uses the discrete-time counterpart of a differentiator followed by a zero-crossing comparator. The slope is the difference between the current sample and the one before it. A peak is found where that slope changes sign. The sample before the crossing is taken as the peak value.

A candidate peak becomes a data-one pulse only when its magnitude reaches a programmable threshold. A candidate below the threshold produces a rejected-peak strobe instead. Every decision is final as soon as it is made.

Genuine transitions alternate in polarity. The block therefore remembers the polarity of the last accepted peak. An accepted peak that repeats that polarity is still reported, but it is marked with a polarity-error flag. Detection is driven entirely by the sample-valid strobe. Cycles without a valid sample change nothing.

Top module: `peak_qualifier`

## Requirements
- R1: While `rst_n` is low at a clock edge, all outputs go to 0, the sample history is cleared and the remembered polarity is forgotten. The first two valid samples after reset can never complete a crossing.
- R2: A positive peak candidate is raised when the previous slope was strictly rising and the new difference (current minus previous sample) is zero or negative. The candidate value is the previous sample.
- R3: A negative peak candidate is raised when the previous slope was strictly falling and the new difference is zero or positive. The candidate value is the previous sample.
- R4: A candidate whose magnitude is greater than or equal to the unsigned `thresh` (sampled together with the completing sample) gives `one_pulse`. Otherwise it gives `rej_pulse`. The two strobes are never high together.
- R5: `one_neg` is 0 for a positive candidate and 1 for a negative candidate. It is valid only with a strobe and is 0 otherwise.
- R6: `pol_err` is high together with `one_pulse` when the accepted peak has the same polarity as the last accepted peak. Rejected peaks do not update the remembered polarity. The first accepted peak after reset never flags an error.
- R7: Cycles with `smp_vld` low leave the history untouched and produce no strobe. A gap between samples does not change any result.
- R8: A zero difference sets the slope to flat. A plateau after a rise gives one peak, at the first plateau sample. A flat stretch followed by a fall gives no peak.
- R9: The strobes rise in the clock cycle after the edge that captures the completing sample. They last exactly one cycle unless the next sample completes another crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | A new sample is present this cycle |
| smp | input | W | Signed two's-complement sample |
| thresh | input | W | Unsigned qualification threshold |
| one_pulse | output | 1 | Accepted peak (data one) strobe |
| one_neg | output | 1 | Polarity of the reported candidate, 1 = negative |
| rej_pulse | output | 1 | Candidate rejected for low amplitude |
| pol_err | output | 1 | Accepted peak repeats the last accepted polarity |

## Verification
Alternating rise-and-fall sequences check that both crossing directions are found at the right sample. A gap of idle cycles inside one slope shows that detection depends only on valid samples. A small dip placed between two large positive peaks separates rejection from acceptance. It also shows that a rejected peak leaves the remembered polarity alone, which is what makes the second positive peak an error. Plateaus after a rise and after a fall separate the zero-difference rule from a plain sign test. Full-scale samples with a threshold of 128 and then 127 probe the inclusive compare at the magnitude edge. A reset in the middle of a stream proves that the old history cannot produce a false crossing.

// File: rtl/pkq_pkg.sv
// Package: shared types of the qualified peak detector.
// Assumes: nothing beyond IEEE 1800-2017.
package pkq_pkg;
    // Direction of the last sample-to-sample difference
    typedef enum logic [1:0] {
        SLOPE_FLAT = 2'd0,
        SLOPE_UP   = 2'd1,
        SLOPE_DOWN = 2'd2
    } slope_e;
endpackage

// File: rtl/pkq_slope.sv
// Module: pkq_slope
// Keeps the previous sample and the sign of the last difference. It flags a
// slope zero-crossing when the current valid sample ends a rise or a fall.
// Assumes: samples are signed two's complement; the history moves only on smp_vld.
module pkq_slope
    import pkq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_vld,
    input  logic signed [W-1:0] smp,
    output logic                cand_pos,
    output logic                cand_neg,
    output logic signed [W-1:0] peak
);
    localparam int DW = W + 1;

    logic signed [W-1:0]  prev_smp;
    logic                 hist_ok;
    slope_e               slope_q;
    logic signed [DW-1:0] diff;

    // Difference between the current and the previous sample, one bit wider
    always_comb begin
        diff = $signed({smp[W-1], smp}) - $signed({prev_smp[W-1], prev_smp});
    end

    // Crossing test against the slope left by the previous difference
    always_comb begin
        cand_pos = smp_vld && hist_ok && (slope_q == SLOPE_UP)   && (diff <= 0);
        cand_neg = smp_vld && hist_ok && (slope_q == SLOPE_DOWN) && (diff >= 0);
        peak     = prev_smp;
    end

    // History update on each valid sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_smp <= '0;
            hist_ok  <= 1'b0;
            slope_q  <= SLOPE_FLAT;
        end else if (smp_vld) begin
            prev_smp <= smp;
            hist_ok  <= 1'b1;
            if (!hist_ok)
                slope_q <= SLOPE_FLAT;
            else if (diff > 0)
                slope_q <= SLOPE_UP;
            else if (diff < 0)
                slope_q <= SLOPE_DOWN;
            else
                slope_q <= SLOPE_FLAT;
        end
    end
endmodule

// File: rtl/pkq_qualify.sv
// Module: pkq_qualify
// Compares the magnitude of a signed peak value with an unsigned threshold
// (inclusive).
// Assumes: the magnitude of the most negative value is representable in W bits.
module pkq_qualify #(
    parameter int W = 8
) (
    input  logic signed [W-1:0] peak,
    input  logic        [W-1:0] thresh,
    output logic                pass
);
    localparam int MW = W + 1;

    logic signed [MW-1:0] ext;
    logic        [MW-1:0] mag;

    // Magnitude in one extra bit, then the inclusive compare
    always_comb begin
        ext  = $signed({peak[W-1], peak});
        mag  = ext[MW-1] ? MW'(-ext) : MW'(ext);
        pass = (mag >= {1'b0, thresh});
    end
endmodule

// File: rtl/pkq_polarity.sv
// Module: pkq_polarity
// Registers the decision strobes and remembers the polarity of the last
// accepted peak, so that a repeated polarity can be flagged.
// Assumes: cand_pos and cand_neg are never high together.
module pkq_polarity (
    input  logic clk,
    input  logic rst_n,
    input  logic cand_pos,
    input  logic cand_neg,
    input  logic pass,
    output logic one_pulse,
    output logic one_neg,
    output logic rej_pulse,
    output logic pol_err
);
    logic cand;
    logic accept;
    logic last_ok;
    logic last_neg;

    // Candidate present and its acceptance
    always_comb begin
        cand   = cand_pos || cand_neg;
        accept = cand && pass;
    end

    // Output strobes and the remembered polarity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            one_pulse <= 1'b0;
            one_neg   <= 1'b0;
            rej_pulse <= 1'b0;
            pol_err   <= 1'b0;
            last_ok   <= 1'b0;
            last_neg  <= 1'b0;
        end else begin
            one_pulse <= accept;
            rej_pulse <= cand && !pass;
            one_neg   <= cand_neg;
            pol_err   <= accept && last_ok && (last_neg == cand_neg);
            if (accept) begin
                last_ok  <= 1'b1;
                last_neg <= cand_neg;
            end
        end
    end
endmodule

// File: rtl/peak_qualifier.sv
// Module: peak_qualifier (top)
// Sampled peak detector: slope zero-crossing, amplitude qualification and
// polarity tracking, with registered one-cycle output strobes.
// Assumes: one sample at most per clock, marked by smp_vld.
module peak_qualifier #(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_vld,
    input  logic signed [W-1:0] smp,
    input  logic        [W-1:0] thresh,
    output logic                one_pulse,
    output logic                one_neg,
    output logic                rej_pulse,
    output logic                pol_err
);
    logic                cand_pos;
    logic                cand_neg;
    logic signed [W-1:0] peak;
    logic                pass;

    pkq_slope #(.W(W)) u_slope (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_vld  (smp_vld),
        .smp      (smp),
        .cand_pos (cand_pos),
        .cand_neg (cand_neg),
        .peak     (peak)
    );

    pkq_qualify #(.W(W)) u_qual (
        .peak   (peak),
        .thresh (thresh),
        .pass   (pass)
    );

    pkq_polarity u_pol (
        .clk       (clk),
        .rst_n     (rst_n),
        .cand_pos  (cand_pos),
        .cand_neg  (cand_neg),
        .pass      (pass),
        .one_pulse (one_pulse),
        .one_neg   (one_neg),
        .rej_pulse (rej_pulse),
        .pol_err   (pol_err)
    );
endmodule

// File: rtl/pkq_checker.sv
// Module: pkq_checker
// Port-level properties of peak_qualifier. It keeps its own copy of the last
// two valid samples and of the last accepted polarity.
// Assumes: bound to every peak_qualifier instance.
module pkq_checker #(
    parameter int W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                smp_vld,
    input logic signed [W-1:0] smp,
    input logic        [W-1:0] thresh,
    input logic                one_pulse,
    input logic                one_neg,
    input logic                rej_pulse,
    input logic                pol_err
);
    logic signed [W-1:0] s1;
    logic signed [W-1:0] s2;
    logic                lok;
    logic                lneg;

    function automatic logic [W:0] mag_of(input logic signed [W-1:0] v);
        logic signed [W:0] e;
        e = $signed({v[W-1], v});
        return e[W] ? (W+1)'(-e) : (W+1)'(e);
    endfunction

    // Shadow of the last two valid samples and the last accepted polarity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1   <= '0;
            s2   <= '0;
            lok  <= 1'b0;
            lneg <= 1'b0;
        end else begin
            if (smp_vld) begin
                s1 <= smp;
                s2 <= s1;
            end
            if (one_pulse) begin
                lok  <= 1'b1;
                lneg <= one_neg;
            end
        end
    end

    p_strobes_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(one_pulse && rej_pulse));
    p_strobe_after_sample_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (one_pulse || rej_pulse) |-> $past(smp_vld));
    p_err_needs_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pol_err |-> one_pulse);
    p_neg_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(one_pulse || rej_pulse) |-> !one_neg);
    p_accept_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        one_pulse |-> (mag_of(s2) >= {1'b0, $past(thresh)}));
    p_reject_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rej_pulse |-> (mag_of(s2) < {1'b0, $past(thresh)}));
    p_pos_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((one_pulse || rej_pulse) && !one_neg) |-> (s1 <= s2));
    p_neg_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((one_pulse || rej_pulse) && one_neg) |-> (s1 >= s2));
    p_alternation_r6: assert property (@(posedge clk) disable iff (!rst_n)
        one_pulse |-> (pol_err == (lok && (lneg == one_neg))));
endmodule

bind peak_qualifier pkq_checker #(.W(W)) u_pkq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_vld   (smp_vld),
    .smp       (smp),
    .thresh    (thresh),
    .one_pulse (one_pulse),
    .one_neg   (one_neg),
    .rej_pulse (rej_pulse),
    .pol_err   (pol_err)
);

// File: tb/peak_qualifier_test.sv
// Scoreboard bench for peak_qualifier: the driver pushes the expected strobes
// for each sample, and the monitor pops and compares them one cycle later.
module peak_qualifier_test;
    localparam int W = 8;
    localparam time CLK_PERIOD = 10ns;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                smp_vld = 1'b0;
    logic signed [W-1:0] smp = '0;
    logic        [W-1:0] thresh = '0;
    logic                one_pulse, one_neg, rej_pulse, pol_err;

    int n_chk = 0;
    int n_bad = 0;
    bit mon_on = 1'b0;
    bit vld_d = 1'b0;
    int cyc = 0;

    logic [3:0] q_exp[$];
    string      q_tag[$];

    // Reference state, built from the requirements
    int have_prev = 0;
    int prev_s = 0;
    int slope = 0;
    int last_ok = 0;
    int last_neg = 0;

    peak_qualifier #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp(smp),
        .thresh(thresh), .one_pulse(one_pulse), .one_neg(one_neg),
        .rej_pulse(rej_pulse), .pol_err(pol_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) vld_d <= smp_vld && rst_n;

    task automatic check(input logic [3:0] got, input logic [3:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: {one,neg,rej,err} got %b expected %b at t=%0t", tag, got, exp, $time);
        end
    endtask

    // Monitor: compares the outputs once per cycle, away from the active edge
    always @(negedge clk) begin
        if (mon_on) begin
            if (vld_d) begin
                if (q_exp.size() == 0) begin
                    n_chk++; n_bad++;
                    $display("FAIL R9: output seen with an empty scoreboard, got %b expected none",
                             {one_pulse, one_neg, rej_pulse, pol_err});
                end else begin
                    logic [3:0] e;
                    string t;
                    e = q_exp.pop_front();
                    t = q_tag.pop_front();
                    check({one_pulse, one_neg, rej_pulse, pol_err}, e, t);
                end
            end else begin
                check({one_pulse, one_neg, rej_pulse, pol_err}, 4'b0000, "R7 R9 idle");
            end
        end
    end

    // Driver: applies one sample and predicts its outcome
    task automatic put(input int s, input int thr, input string tag);
        bit one, neg, rej, err;
        one = 0; neg = 0; rej = 0; err = 0;
        @(negedge clk);
        smp_vld = 1'b1;
        smp     = s[W-1:0];
        thresh  = thr[W-1:0];
        if (have_prev != 0) begin
            int d;
            d = s - prev_s;
            if ((slope == 1 && d <= 0) || (slope == -1 && d >= 0)) begin
                int m;
                neg = (slope == -1);
                m = (prev_s < 0) ? -prev_s : prev_s;
                if (m >= thr) begin
                    one = 1;
                    err = (last_ok != 0) && (last_neg == int'(neg));
                    last_ok = 1;
                    last_neg = int'(neg);
                end else begin
                    rej = 1;
                end
            end
            slope = (d > 0) ? 1 : ((d < 0) ? -1 : 0);
        end else begin
            slope = 0;
        end
        prev_s = s;
        have_prev = 1;
        q_exp.push_back({one, neg, rej, err});
        if (one && err)      q_tag.push_back("R6 repeated polarity");
        else if (one && !neg) q_tag.push_back("R2 R5 positive accept");
        else if (one)         q_tag.push_back("R3 R5 negative accept");
        else if (rej)         q_tag.push_back("R4 reject");
        else                  q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_vld = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        mon_on = 1'b0;
        smp_vld = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check({one_pulse, one_neg, rej_pulse, pol_err}, 4'b0000, "R1 reset state");
        have_prev = 0; slope = 0; last_ok = 0; last_neg = 0;
        rst_n = 1'b1;
        mon_on = 1'b1;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish, got %0d cycles expected < 20000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R2 R3: alternating peaks, then a gap inside a rise (R7)
        put(0, 20, "R1 first"); put(10, 20, "R1 second"); put(30, 20, "R2 rise");
        put(50, 20, "R2 rise"); put(40, 20, "R2 end");
        put(20, 20, "R3 fall"); put(-10, 20, "R3 fall"); put(-40, 20, "R3 fall"); put(-30, 20, "R3 end");
        put(10, 20, "R2 rise"); put(30, 20, "R2 rise"); put(25, 20, "R2 end");
        put(40, 20, "R3 end"); idle(3); put(35, 20, "R7 after gap");
        // R4 R6: a rejected dip between two positive accepts
        put(30, 50, "R4 fall"); put(10, 50, "R4 fall"); put(20, 50, "R4 dip");
        put(60, 50, "R6 rise"); put(70, 50, "R6 rise"); put(65, 50, "R6 end");
        // R8: plateaus
        put(0, 0, "R8 fall"); put(-20, 0, "R8 fall"); put(-20, 0, "R8 plateau");
        put(-20, 0, "R8 flat"); put(-10, 0, "R8 rise after flat");
        put(5, 0, "R8 rise"); put(5, 0, "R8 plateau"); put(5, 0, "R8 flat");
        put(0, 0, "R8 fall after flat");
        // R4: full-scale magnitudes at the inclusive edge
        put(0, 128, "R4 edge"); put(-128, 128, "R4 edge"); put(-100, 128, "R4 edge");
        put(127, 128, "R4 edge"); put(100, 128, "R4 edge");
        put(120, 127, "R4 edge"); put(127, 127, "R4 edge"); put(126, 127, "R4 edge");
        idle(2);
        // R1: reset mid-stream clears history and polarity
        do_reset();
        put(10, 5, "R1 first after reset"); put(20, 5, "R1 second after reset");
        put(10, 5, "R1 end"); put(30, 5, "R3 end"); put(20, 5, "R2 end");
        idle(3);
        if (q_exp.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL R9: %0d expected items left over, expected 0", q_exp.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule